// File: doc/BRIEF.md
# Conversion Result Buffer with Serial Readout

This block collects 12-bit converter results as a scan produces them and hands them to a host over a four-wire serial port. A scan yields one result for each selected single-ended channel or differential pair, and may add one temperature result. Each result goes into a queue together with a tag. The tag marks the code as plain binary (unipolar) or as two's complement (bipolar or temperature). When the last result of a scan arrives, an active-low completion flag drops. This tells the host that the data is ready.

The host lowers its select line to start reading. The completion flag then returns high, and the oldest queued result is loaded into a 16-bit frame. The frame has four zero bits in front of the 12-bit code and goes out MSB first. Each falling edge of the serial clock advances the line by one bit. The sixteenth falling edge loads the next result, so frames follow each other with no gap while select stays low. A read from an empty queue sends zeros. A result pushed into a full queue is dropped, and a sticky overflow flag is set.

The serial clock and select inputs are sampled in the system clock domain, and edges are found by comparing each input with its registered copy. The transmitter is a two-state machine. `TX_IDLE` is the state while select is high; a select falling edge loads a frame and moves to `TX_SHIFT`. `TX_SHIFT` shifts on each serial clock falling edge, reloads on every sixteenth one, and goes back to `TX_IDLE` as soon as select is seen high.

Top module: `res_readout`

## Requirements
- R1: After reset, `dout` is 0, `eoc_n` is 1, `ovf` is 0 and `frame_twos` is 0.
- R2: A frame is 16 bits, MSB first. Bits 15..12 are zero and bits 11..0 hold the code. Bit 15 appears on `dout` one clock after the select falling edge is sampled. Each later bit appears one clock after a sampled `sclk` falling edge.
- R3: A push that finds the queue holding `DEPTH` entries, with no pop in the same cycle, is dropped. `ovf` then goes to 1 and stays at 1 until reset.
- R4: Results leave in the order in which they were pushed.
- R5: A frame loaded while the queue is empty is all zeros, and `frame_twos` is 0 for that frame.
- R6: One clock after a push with `res_last`=1, `eoc_n` is 0.
- R7: One clock after a select falling edge, `eoc_n` is 1, unless R8 applies.
- R8: If a push with `res_last`=1 falls in the same cycle as a select falling edge, `eoc_n` is 0 afterwards.
- R9: A push and a pop in the same cycle on a full queue are both accepted, and `ovf` stays 0. A pop in the same cycle as a push on an empty queue yields a zero frame, and the pushed entry is kept.
- R10: `frame_twos` holds the tag of the frame being shifted out: 1 for two's complement, 0 for binary.
- R11: While select stays low, the 16th `sclk` falling edge of a frame loads the next entry. Its bit 15 appears on `dout` one clock later.
- R12: `dout` is 0 while `cs_n` is high, from one clock after select is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Push strobe for one result |
| res_code | input | 12 | Conversion code |
| res_twos | input | 1 | Tag: 1 for two's complement, 0 for binary |
| res_last | input | 1 | Marks the final result of a scan |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| cs_n | input | 1 | Active-low select, sampled by `clk` |
| dout | output | 1 | Serial data |
| frame_twos | output | 1 | Tag of the frame being shifted |
| eoc_n | output | 1 | Active-low scan-complete flag |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Two pairs of events can land in the same clock edge. The first is a push and a frame load, which is a pop. The second is the completion flag being set by a push marked last and cleared by a select falling edge. The bench provokes both by changing `res_valid` and `cs_n` on the same falling clock edge, once with the queue full and once with it empty. It then checks the order of every later frame, the overflow flag, and the completion flag against its own queue model.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int CODE_W  = 12;
    localparam int FRAME_W = 16;
    localparam int PAD_W   = FRAME_W - CODE_W;
    localparam int BIT_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic              twos;
        logic [CODE_W-1:0] code;
    } rr_entry_t;

    typedef enum logic {
        TX_IDLE,
        TX_SHIFT
    } tx_state_t;
endpackage

// File: rtl/rr_fifo.sv
module rr_fifo
    import rr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  rr_entry_t wr_entry,
    input  logic      rd_en,
    output rr_entry_t rd_entry,
    output logic      empty,
    output logic      dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    rr_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            full, do_rd, do_wr;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_rd   = rd_en & ~empty;
    assign do_wr   = wr_en & (~full | do_rd);
    assign dropped = wr_en & ~do_wr;
    assign rd_entry = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rr_frame_tx.sv
module rr_frame_tx
    import rr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sclk,
    input  logic      cs_n,
    input  rr_entry_t head,
    input  logic      head_valid,
    output logic      pop,
    output logic      sel_start,
    output logic      dout,
    output logic      frame_twos
);
    tx_state_t           state_q, state_d;
    logic                sclk_q, cs_q;
    logic [FRAME_W-1:0]  shreg;
    logic [BIT_W-1:0]    bit_q;
    logic                twos_q;
    logic                cs_fall, sclk_fall, last_bit, load, shift;

    assign cs_fall   = cs_q & ~cs_n;
    assign sclk_fall = sclk_q & ~sclk;
    assign last_bit  = (bit_q == BIT_W'(FRAME_W - 1));
    assign sel_start = (state_q == TX_IDLE) & cs_fall;
    assign load      = sel_start |
                       ((state_q == TX_SHIFT) & ~cs_n & sclk_fall & last_bit);
    assign shift     = (state_q == TX_SHIFT) & ~cs_n & sclk_fall & ~last_bit;
    assign pop       = load & head_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (cs_fall) state_d = TX_SHIFT;
            TX_SHIFT: if (cs_n)    state_d = TX_IDLE;
        endcase
    end

    // state register and input edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            sclk_q  <= sclk;
            cs_q    <= cs_n;
        end
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bit_q  <= '0;
            twos_q <= 1'b0;
        end else if (load) begin
            shreg  <= head_valid ? {{PAD_W{1'b0}}, head.code} : '0;
            twos_q <= head_valid & head.twos;
            bit_q  <= '0;
        end else if (shift) begin
            shreg  <= {shreg[FRAME_W-2:0], 1'b0};
            bit_q  <= bit_q + 1'b1;
        end
    end

    // outputs per state
    always_comb begin
        dout       = 1'b0;
        frame_twos = 1'b0;
        unique case (state_q)
            TX_IDLE:  ;
            TX_SHIFT: begin
                dout       = shreg[FRAME_W-1];
                frame_twos = twos_q;
            end
        endcase
    end
endmodule

// File: rtl/res_readout.sv
module res_readout
    import rr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CODE_W-1:0] res_code,
    input  logic              res_twos,
    input  logic              res_last,
    input  logic              sclk,
    input  logic              cs_n,
    output logic              dout,
    output logic              frame_twos,
    output logic              eoc_n,
    output logic              ovf
);
    rr_entry_t in_entry, head;
    logic      empty, dropped, pop, sel_start;

    assign in_entry = '{twos: res_twos, code: res_code};

    rr_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (res_valid),
        .wr_entry (in_entry),
        .rd_en    (pop),
        .rd_entry (head),
        .empty    (empty),
        .dropped  (dropped)
    );

    rr_frame_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .head       (head),
        .head_valid (~empty),
        .pop        (pop),
        .sel_start  (sel_start),
        .dout       (dout),
        .frame_twos (frame_twos)
    );

    // completion flag: a finished scan wins over a read start in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     eoc_n <= 1'b1;
        else if (res_valid && res_last) eoc_n <= 1'b0;
        else if (sel_start)             eoc_n <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (dropped) ovf <= 1'b1;
    end
endmodule

// File: rtl/res_readout_chk.sv
module res_readout_chk (
    input logic clk,
    input logic rst_n,
    input logic res_valid,
    input logic res_last,
    input logic cs_n,
    input logic dout,
    input logic eoc_n,
    input logic ovf
);
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(res_valid));

    p_eoc_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_last) |=> !eoc_n);

    p_eoc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && !(res_valid && res_last)) |=> eoc_n);

    p_dout_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !dout);
endmodule

bind res_readout res_readout_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_last  (res_last),
    .cs_n      (cs_n),
    .dout      (dout),
    .eoc_n     (eoc_n),
    .ovf       (ovf)
);

// File: tb/res_readout_bench.sv
module res_readout_bench;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_code = '0;
    logic        res_twos = 1'b0;
    logic        res_last = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        dout, frame_twos, eoc_n, ovf;

    int n_checks = 0;
    int n_fail   = 0;

    logic [12:0] model[$];
    logic        ovf_exp = 1'b0;
    logic [12:0] cur = '0;
    logic        cur_v = 1'b0;

    always #10 clk = ~clk;

    res_readout #(.DEPTH(DEPTH)) u_res_readout (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_code(res_code),
        .res_twos(res_twos), .res_last(res_last), .sclk(sclk), .cs_n(cs_n),
        .dout(dout), .frame_twos(frame_twos), .eoc_n(eoc_n), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] frame_of(input logic v, input logic [12:0] e);
        return v ? {4'b0000, e[11:0]} : 16'h0000;
    endfunction

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic model_push(input logic [12:0] e);
        if (model.size() < DEPTH) model.push_back(e);
        else ovf_exp = 1'b1;
    endtask

    task automatic model_pop();
        cur_v = (model.size() > 0);
        cur   = cur_v ? model.pop_front() : 13'h0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; res_valid = 1'b0;
        model.delete(); ovf_exp = 1'b0; cur_v = 1'b0;
        waitn(3);
        rst_n = 1'b1;
        waitn(2);
    endtask

    task automatic push(input logic [11:0] code, input logic twos, input logic last);
        @(negedge clk);
        res_valid = 1'b1; res_code = code; res_twos = twos; res_last = last;
        model_push({twos, code});
        @(negedge clk);
        res_valid = 1'b0; res_last = 1'b0;
    endtask

    task automatic cs_lo();
        @(negedge clk);
        cs_n = 1'b0;
        model_pop();
        waitn(2);
    endtask

    task automatic cs_hi();
        @(negedge clk);
        cs_n = 1'b1;
        waitn(2);
        check(dout == 1'b0, "R12 dout idle", dout, 0);
    endtask

    // reads n frames; each 16th falling edge loads the next one (R11)
    task automatic read_frames(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [15:0] got;
            logic [15:0] exp;
            exp = frame_of(cur_v, cur);
            check(frame_twos == (cur_v & cur[12]), {req, " R10 tag"},
                  frame_twos, cur_v & cur[12]);
            for (int b = 15; b >= 0; b--) begin
                got[b] = dout;
                sclk = 1'b1; waitn(2);
                sclk = 1'b0; waitn(2);
            end
            check(got == exp, {req, " R2 frame"}, got, exp);
            model_pop();
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        do_reset();
        // R1 reset state
        check(dout == 0, "R1 dout", dout, 0);
        check(eoc_n == 1, "R1 eoc_n", eoc_n, 1);
        check(ovf == 0, "R1 ovf", ovf, 0);
        check(frame_twos == 0, "R1 frame_twos", frame_twos, 0);

        // directed scan of three results, R4 order, R6/R7 flag, R5 empty tail
        push(12'hA5C, 1'b0, 1'b0);
        push(12'h801, 1'b1, 1'b0);
        push(12'h7FF, 1'b1, 1'b1);
        check(eoc_n == 0, "R6 eoc low", eoc_n, 0);
        cs_lo();
        check(eoc_n == 1, "R7 eoc high", eoc_n, 1);
        read_frames(3, "R4 R11 burst");
        read_frames(1, "R5 empty");
        cs_hi();

        // R3 overflow: 17 pushes, 16 kept, 17th frame zeros
        do_reset();
        for (int i = 0; i < DEPTH + 1; i++) push(12'(i * 37 + 5), i[0], 1'b0);
        check(ovf == 1, "R3 ovf set", ovf, 1);
        cs_lo();
        read_frames(DEPTH + 1, "R3 R4 drain");
        cs_hi();
        check(ovf == 1, "R3 ovf sticky", ovf, 1);

        // R9 full queue: push and pop in same cycle
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(12'(i * 91 + 3), ~i[0], 1'b0);
        @(negedge clk);
        cs_n = 1'b0; res_valid = 1'b1; res_code = 12'hC3A; res_twos = 1'b1;
        model_pop();
        model_push({1'b1, 12'hC3A});
        @(negedge clk);
        res_valid = 1'b0;
        waitn(1);
        check(ovf == 0, "R9 no ovf on full push+pop", ovf, 0);
        read_frames(DEPTH + 1, "R9 full");
        cs_hi();

        // R8 + R9 empty queue: last push meets select fall
        do_reset();
        @(negedge clk);
        cs_n = 1'b0; res_valid = 1'b1; res_last = 1'b1;
        res_code = 12'h3E9; res_twos = 1'b0;
        model_pop();
        model_push({1'b0, 12'h3E9});
        @(negedge clk);
        res_valid = 1'b0; res_last = 1'b0;
        check(eoc_n == 0, "R8 eoc stays low", eoc_n, 0);
        waitn(1);
        read_frames(1, "R9 empty zero frame");
        check(eoc_n == 0, "R8 eoc still low", eoc_n, 0);
        cs_hi();
        cs_lo();
        check(eoc_n == 1, "R7 eoc high", eoc_n, 1);
        read_frames(2, "R9 kept entry");
        cs_hi();

        // random scans and reads
        do_reset();
        for (int it = 0; it < 20; it++) begin
            int np;
            int nr;
            np = 1 + int'($urandom % 20);
            nr = int'($urandom % 20);
            for (int j = 0; j < np; j++)
                push(12'($urandom), 1'($urandom), (j == np - 1));
            check(eoc_n == 0, "R6 random eoc", eoc_n, 0);
            check(ovf == ovf_exp, "R3 random ovf", ovf, ovf_exp);
            cs_lo();
            check(eoc_n == 1, "R7 random eoc", eoc_n, 1);
            read_frames(nr, "R4 random");
            cs_hi();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule